// File: doc/BRIEF.md
# Sample-and-Hold Acquisition Timer

This block decides when an analog sample-and-hold stage stops tracking its input and holds it. Each acquisition is timed from a periodic PWM synchronisation pulse. On a sync edge a down-counter is loaded from a 16-bit delay setting. The stage tracks while the counter runs and switches to hold when the count is used up. If the count is still running when the next sync pulse arrives, hold is forced at that edge.

After hold, the block issues a one-clock conversion-start strobe to an abstract converter. It captures the word the converter returns and presents it on a sync edge, together with a valid flag. A word that is not a completed conversion is marked by setting its least significant bit. A conversion normally runs in the sync period after the hold and is presented one period later. When hold falls inside the high time of the sync pulse, the conversion runs in the same period. For several channels, one instance is placed per channel.

Terms used below. The *sample point* is the first enabled clock edge at which `sync_in` is seen high after being low. The *detection edge* is the enabled clock edge that follows it. *P* is the sync period in enabled clocks and *H* is its high time. *L* is the programmed delay, with values below 3 raised to 3.

Top module: `sh_acq_timer`

## Requirements
- R1: While `rst` is high, and after reset until the first sync detection edge, `hold_o`, `conv_start_o` and `result_valid_o` are 0, so the stage tracks.
- R2: An acquisition loaded at the detection edge of a sync pulse drives `hold_o` high L+2 enabled clocks after that pulse's sample point, provided L+1 < P.
- R3: A programmed delay of 0, 1 or 2 behaves as 3, so the earliest hold comes 5 enabled clocks after the sample point.
- R4: When L+1 >= P, hold is forced at the next detection edge (P+1 enabled clocks after the sample point). The conversion strobe comes in that same clock, and the result is presented at the detection edge after it.
- R5: When hold occurs while the registered sync level is low, `conv_start_o` pulses for exactly one clock at the next detection edge. The result is presented at the detection edge that follows.
- R6: When hold occurs while the registered sync level is still high (L+1 < H), `conv_start_o` pulses in the same clock as hold rises. The result is presented at the very next detection edge.
- R7: A presented completed conversion sets `result_valid_o` to 1 and puts the converter word on `result_o` with bit 0 cleared. At every other detection edge, including a presentation edge with no converter completion since the strobe, bit 0 of `result_o` becomes 1 and `result_valid_o` becomes 0.
- R8: The delay setting is captured only when an acquisition is loaded. A change during an acquisition does not move that acquisition's hold, and it applies to the next one.
- R9: While `ce` is low, sync sampling, the counter and `hold_o` do not advance, so the hold delay is counted in enabled clocks.
- R10: At each presentation edge `hold_o` returns to 0 and a new acquisition is loaded from the delay setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for timing and sync sampling |
| sync_in | input | 1 | PWM synchronisation pulse level |
| delay_cfg | input | CW (16) | Programmed sample delay in enabled clocks |
| conv_done | input | 1 | One-clock completion pulse from the converter |
| conv_data | input | DW (12) | Converter word, valid with `conv_done` |
| hold_o | output | 1 | 1 = hold, 0 = track |
| conv_start_o | output | 1 | One-clock conversion-start strobe |
| result_o | output | DW (12) | Presented conversion word; bit 0 = 1 marks invalid |
| result_valid_o | output | 1 | 1 while `result_o` holds a completed conversion |

## Verification
The hardest situation to reach is the boundary where the counter expires in the same clock as the next sync detection, or within the pulse high time. Only the exact pairing of delay, period and high time reaches it. The bench sweeps every delay from 0 to just past the period, for two periods and two high times. It therefore crosses the clamp floor, the in-pulse window, the coincident-expiry case and the forced-hold region in one pass. Separate runs freeze the clock enable in mid-count, change the delay in mid-acquisition, and withhold the converter completion.

// File: rtl/sh_acq_pkg.sv
package sh_acq_pkg;
  // Phase of the acquisition sequence, advanced on enabled clocks
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // after reset, waiting for the first sync pulse
    PH_ACQ  = 2'd1,  // tracking, delay counter running
    PH_WAIT = 2'd2,  // holding, conversion deferred to the next period
    PH_CONV = 2'd3   // converting, result presented at the next sync edge
  } phase_e;
endpackage

// File: rtl/sh_sync_detect.sv
module sh_sync_detect (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic sync_i,
  output logic level_o,
  output logic rise_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else if (ce) begin
      s1_q <= sync_i;
      s2_q <= s1_q;
    end
  end

  assign level_o = s1_q;
  assign rise_o  = s1_q & ~s2_q;
endmodule

// File: rtl/sh_delay_counter.sv
module sh_delay_counter #(
  parameter int CW       = 16,
  parameter int MIN_LOAD = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          load_i,
  input  logic [CW-1:0] delay_i,
  output logic          zero_o
);
  localparam logic [CW-1:0] FLOOR = CW'(MIN_LOAD);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  assign load_val = (delay_i < FLOOR) ? FLOOR : delay_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val;
    end else if (ce && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  AST_LOAD_FLOOR: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q >= FLOOR)); // R3
  AST_CE_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ce && !load_i) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/sh_conv_capture.sv
module sh_conv_capture #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          done_i,
  input  logic [DW-1:0] data_i,
  output logic          have_o,
  output logic [DW-1:0] data_o
);
  logic          armed_q;
  logic          have_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      have_q  <= 1'b0;
      data_q  <= '0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      have_q  <= 1'b0;
    end else if (armed_q && done_i) begin
      armed_q <= 1'b0;
      have_q  <= 1'b1;
      data_q  <= data_i;
    end
  end

  assign have_o = have_q;
  assign data_o = data_q;

  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (have_q && !start_i) |=> $stable(data_q)); // R7
endmodule

// File: rtl/sh_sequencer.sv
module sh_sequencer
  import sh_acq_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          rise_i,
  input  logic          level_i,
  input  logic          zero_i,
  input  logic          have_i,
  input  logic [DW-1:0] data_i,
  output logic          load_o,
  output logic          hold_o,
  output logic          conv_start_o,
  output logic [DW-1:0] result_o,
  output logic          valid_o
);
  phase_e        st_q;
  logic          hold_q;
  logic          cs_q;
  logic [DW-1:0] res_q;
  logic          valid_q;

  // A new acquisition is loaded at the first sync edge and at each presentation edge
  assign load_o = ce && rise_i && ((st_q == PH_IDLE) || (st_q == PH_CONV));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= PH_IDLE;
      hold_q  <= 1'b0;
      cs_q    <= 1'b0;
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      cs_q <= 1'b0;
      if (ce) begin
        if (rise_i) begin
          unique case (st_q)
            PH_IDLE: begin
              st_q     <= PH_ACQ;
              hold_q   <= 1'b0;
              res_q[0] <= 1'b1;
              valid_q  <= 1'b0;
            end
            PH_ACQ, PH_WAIT: begin
              st_q     <= PH_CONV;
              hold_q   <= 1'b1;
              cs_q     <= 1'b1;
              res_q[0] <= 1'b1;
              valid_q  <= 1'b0;
            end
            PH_CONV: begin
              st_q   <= PH_ACQ;
              hold_q <= 1'b0;
              if (have_i) begin
                res_q   <= {data_i[DW-1:1], 1'b0};
                valid_q <= 1'b1;
              end else begin
                res_q[0] <= 1'b1;
                valid_q  <= 1'b0;
              end
            end
            default: st_q <= PH_IDLE;
          endcase
        end else if ((st_q == PH_ACQ) && zero_i) begin
          hold_q <= 1'b1;
          if (level_i) begin
            st_q <= PH_CONV;
            cs_q <= 1'b1;
          end else begin
            st_q <= PH_WAIT;
          end
        end
      end
    end
  end

  assign hold_o       = hold_q;
  assign conv_start_o = cs_q;
  assign result_o     = res_q;
  assign valid_o      = valid_q;

  AST_FORCED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ce && rise_i && (st_q == PH_ACQ)) |=> hold_q); // R4
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> !cs_q); // R5
  AST_START_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    cs_q |-> hold_q); // R6
  AST_VALID_EVEN: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> !res_q[0]); // R7
  AST_RELOAD_TRACK: assert property (@(posedge clk) disable iff (rst)
    load_o |=> !hold_q); // R10
  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(hold_q)); // R9
endmodule

// File: rtl/sh_acq_timer.sv
module sh_acq_timer #(
  parameter int CW       = 16,
  parameter int DW       = 12,
  parameter int MIN_LOAD = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          sync_in,
  input  logic [CW-1:0] delay_cfg,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  output logic          hold_o,
  output logic          conv_start_o,
  output logic [DW-1:0] result_o,
  output logic          result_valid_o
);
  logic          level, rise, zero, load, have;
  logic [DW-1:0] cap_data;

  sh_sync_detect u_sync (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .sync_i  (sync_in),
    .level_o (level),
    .rise_o  (rise)
  );

  sh_delay_counter #(.CW(CW), .MIN_LOAD(MIN_LOAD)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .load_i  (load),
    .delay_i (delay_cfg),
    .zero_o  (zero)
  );

  sh_conv_capture #(.DW(DW)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .start_i (conv_start_o),
    .done_i  (conv_done),
    .data_i  (conv_data),
    .have_o  (have),
    .data_o  (cap_data)
  );

  sh_sequencer #(.DW(DW)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .ce           (ce),
    .rise_i       (rise),
    .level_i      (level),
    .zero_i       (zero),
    .have_i       (have),
    .data_i       (cap_data),
    .load_o       (load),
    .hold_o       (hold_o),
    .conv_start_o (conv_start_o),
    .result_o     (result_o),
    .valid_o      (result_valid_o)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!hold_o && !result_valid_o && !conv_start_o)); // R1
  AST_NO_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    (conv_start_o && !load) |=> !conv_start_o); // R5
endmodule

// File: tb/tb_sh_acq_timer.sv
`timescale 1ns/1ps
module tb_sh_acq_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b1;
  logic        sync_in = 1'b0;
  logic [15:0] delay_cfg = '0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        hold_o, conv_start_o, result_valid_o;
  logic [11:0] result_o;

  int ec = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) ec <= ec + 1;

  sh_acq_timer dut (
    .clk(clk), .rst(rst), .ce(ce), .sync_in(sync_in), .delay_cfg(delay_cfg),
    .conv_done(conv_done), .conv_data(conv_data), .hold_o(hold_o),
    .conv_start_o(conv_start_o), .result_o(result_o), .result_valid_o(result_valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampv(input int d);
    return (d < 3) ? 3 : d;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic run(input int d, input int d2, input int p, input int h, input int f, input bit conv_en);
    int l, l2, e0, hold_first, hold2, cs_first, cs_cnt, pend;
    int exp_hold, exp_cs, exp_valid, exp_hold2;
    bit forced, inpulse, seen_low, v_at, h_at, v_p1, r0_p1;
    logic [11:0] r_at, dat;
    l = clampv(d);
    l2 = clampv(d2);
    forced = (l + 1 >= p);
    inpulse = !forced && (l + 1 < h);
    exp_hold = 1 + imin(l + 1, p) + f;
    exp_cs = inpulse ? exp_hold : p + 1;
    exp_valid = inpulse ? p + 1 : 2 * p + 1;
    exp_hold2 = exp_valid + imin(l2 + 1, p);
    dat = 12'((d * 173 + 91) ^ 16'h05A5);
    hold_first = -1; hold2 = -1; cs_first = -1; cs_cnt = 0; pend = 0;
    seen_low = 0; v_at = 0; h_at = 1; v_p1 = 1; r0_p1 = 0; r_at = '0;

    rst = 1'b1; ce = 1'b1; sync_in = 1'b0; delay_cfg = 16'(d); conv_done = 1'b0; conv_data = dat;
    repeat (3) begin
      @(negedge clk);
      chk(!hold_o && !result_valid_o && !conv_start_o, "R1 reset", {29'd0, hold_o, result_valid_o, conv_start_o}, 0);
    end
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!hold_o && !result_valid_o && !conv_start_o, "R1 before first sync", {29'd0, hold_o, result_valid_o, conv_start_o}, 0);
    end
    e0 = ec + 1;
    for (int t = 0; t < 3 * p + 8 + f; t++) begin
      int r, o;
      r = ec + 1 - e0;
      sync_in = ((r % p) < h);
      ce = !((f > 0) && (r >= 4) && (r < 4 + f));
      delay_cfg = (r >= 2) ? 16'(d2) : 16'(d);
      conv_done = (pend == 1);
      @(negedge clk);
      o = ec - e0;
      if (pend > 0) pend--;
      if (conv_en && conv_start_o) pend = 2;
      if (hold_o && hold_first < 0) hold_first = o;
      if (hold_first >= 0 && !hold_o) seen_low = 1;
      if (seen_low && hold_o && hold2 < 0) hold2 = o;
      if (conv_start_o && cs_first < 0) cs_first = o;
      if (conv_start_o && o < exp_valid) cs_cnt++;
      if (o == exp_valid) begin v_at = result_valid_o; r_at = result_o; h_at = hold_o; end
      if (o == p + 1) begin v_p1 = result_valid_o; r0_p1 = result_o[0]; end
    end

    if (f > 0)        chk(hold_first == exp_hold, "R9 hold delay with ce frozen", hold_first, exp_hold);
    else if (forced)  chk(hold_first == exp_hold, "R4 forced hold edge", hold_first, exp_hold);
    else if (d < 3)   chk(hold_first == exp_hold, "R3 clamped hold edge", hold_first, exp_hold);
    else              chk(hold_first == exp_hold, "R2 hold edge", hold_first, exp_hold);
    if (inpulse) chk(cs_first == exp_cs, "R6 in-pulse start edge", cs_first, exp_cs);
    else         chk(cs_first == exp_cs, "R5 deferred start edge", cs_first, exp_cs);
    chk(cs_cnt == 1, "R5 one start strobe per acquisition", cs_cnt, 1);
    if (conv_en) begin
      chk(v_at == 1'b1, inpulse ? "R6 valid at next sync" : (forced ? "R4 valid two syncs later" : "R5 valid two syncs later"), v_at, 1);
      chk(r_at == {dat[11:1], 1'b0}, "R7 presented word", r_at, {dat[11:1], 1'b0});
    end else begin
      chk(v_at == 1'b0 && r_at[0] == 1'b1, "R7 missing conversion marked", {v_at, r_at[0]}, 1);
    end
    if (!inpulse) chk(v_p1 == 1'b0 && r0_p1 == 1'b1, "R7 acquire-phase edge marked", {v_p1, r0_p1}, 1);
    chk(h_at == 1'b0, "R10 track at presentation edge", h_at, 0);
    chk(hold2 == exp_hold2, "R8 next acquisition uses new delay", hold2, exp_hold2);
  endtask

  initial begin
    int ps[2] = '{12, 20};
    int hs[2] = '{3, 6};
    foreach (ps[i]) begin
      foreach (hs[j]) begin
        for (int d = 0; d <= ps[i] + 2; d++) begin
          run(d, (d * 7 + 3) % (ps[i] + 3), ps[i], hs[j], 0, 1'b1);
        end
      end
    end
    run(65535, 4, 12, 3, 0, 1'b1);
    run(10, 5, 40, 3, 8, 1'b1);
    run(5, 5, 20, 3, 0, 1'b0);
    run(2, 2, 20, 6, 0, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule